// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

The block gathers 32 interrupt lines and turns them into two requests for a processor: a normal request and a fast request. Line 0 belongs to the fast path and never drives the normal request. Line 1 is not a pin of its own. It is the OR of a small group of system-peripheral request lines. Each line has an enable bit, a 3-bit priority and a 32-bit vector word. It can be set to capture edges or to follow a level. Lines marked as external can also have their sense inverted, so that they react to falling edges or to low levels.

Software talks to the block over a simple word-wide register port. A read of the vector register acknowledges the winning line. The read returns that line's vector, clears the line's edge capture and pushes the line onto an in-service stack. A write to the end-of-interrupt register pops the stack. While a line is in service, the normal request is raised only for a line of strictly higher priority, so handlers can nest. The fast path has its own acknowledge register and does not use the stack.

Top module: `vpic_ctrl`

## Requirements
- R1: After reset, irq_o and fiq_o are low, every enable bit is 0, and every configuration and vector word reads as 0.
- R2: The enable register at word address 0x40 reads back the enable bits. A write to 0x40 sets the bits written as 1, and a write to 0x41 clears them. A disabled line never raises irq_o, but its pending state still reads as 1 at word address 0x43.
- R3: Line 0 drives only fiq_o. fiq_o is high when line 0 is pending and enabled. A read of word address 0x47 returns vector 0, clears the edge capture of line 0 and pushes nothing onto the in-service stack.
- R4: Line 1 is pending from the OR of the sys_src_i lines. The src_i[1] pin has no effect.
- R5: In edge mode (configuration bit 5 = 0), an inactive-to-active transition sets a capture bit. The line stays pending after the input returns to inactive, until the line is acknowledged.
- R6: In level mode (configuration bit 5 = 1), the line is pending exactly while its input is active. An acknowledge does not remove it while the input is held.
- R7: Configuration bit 6 inverts the active sense, giving falling-edge or low-level operation. It does this only on the external lines 0, 29, 30 and 31. On every other line the bit is ignored.
- R8: Configuration word i (addresses 0x00 to 0x1F) holds the priority in bits 2:0, along with bits 5 and 6. Vector word i sits at 0x20+i. A read of 0x44 picks, among the enabled pending lines 1 to 31, the one with the highest priority, with the lower line number winning a tie. The read returns that line's vector.
- R9: A vector read pushes the acknowledged line onto the in-service stack. While the stack is not empty, irq_o is raised only for a candidate whose priority is strictly higher than the top entry. A write to 0x46 pops one entry.
- R10: A read of 0x45 returns bit 31 = 1 and the top line number in bits 4:0 while the stack is not empty, and 0 when it is empty.
- R11: A read of 0x44 while irq_o is low returns 0 and leaves the stack unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt lines; bit 1 unused |
| sys_src_i | input | 4 | System-peripheral requests, OR-ed into line 1 |
| bus_en_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The hardest state to reach from the ports is a three-deep nesting order. In it, a higher-priority line preempts one already in service, and two equal-priority lines plus a lower one wait behind it. Each end-of-interrupt must then reopen the request for exactly the right line. The bench latches three edge lines in the same cycle, acknowledges the tie winner, and then brings in a fourth line of higher priority. It then unwinds the stack one pop at a time, reading the current-source register and the vector after each pop. Level-sensitive lines held across an acknowledge, and polarity applied to internal lines, are driven as separate phases.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int NSRC    = 32;
  localparam int PRIO_W  = 3;
  localparam int DW      = 32;
  localparam int AW      = 8;
  localparam int SRC_W   = $clog2(NSRC);
  localparam int LVL_BIT = 5;
  localparam int POL_BIT = 6;
  localparam logic [NSRC-1:0] EXT_MASK = 32'hE000_0001;

  localparam logic [AW-1:0] A_EN_SET = 8'h40;
  localparam logic [AW-1:0] A_EN_CLR = 8'h41;
  localparam logic [AW-1:0] A_PEND   = 8'h43;
  localparam logic [AW-1:0] A_VEC    = 8'h44;
  localparam logic [AW-1:0] A_CUR    = 8'h45;
  localparam logic [AW-1:0] A_EOI    = 8'h46;
  localparam logic [AW-1:0] A_FVEC   = 8'h47;
endpackage

// File: rtl/vpic_src_cond.sv
module vpic_src_cond #(
  parameter int NSRC = 32,
  parameter logic [NSRC-1:0] EXT_MASK = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] raw_i,
  input  logic [NSRC-1:0] level_i,
  input  logic [NSRC-1:0] lowpol_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic act, prev_q, cap_q;
    if (EXT_MASK[g]) begin : g_ext
      assign act = raw_i[g] ^ lowpol_i[g];
    end else begin : g_int
      assign act = raw_i[g];
    end
    // prev resets high so a line already active at reset is not seen as an edge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q <= 1'b1;
        cap_q  <= 1'b0;
      end else begin
        prev_q <= act;
        cap_q  <= (cap_q & ~clr_i[g]) | (act & ~prev_q);
      end
    end
    assign pend_o[g] = level_i[g] ? act : cap_q;
  end
endmodule

// File: rtl/vpic_prio_sel.sv
module vpic_prio_sel #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  localparam int SRC_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             cand_i,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
  output logic                        valid_o,
  output logic [SRC_W-1:0]            id_o,
  output logic [PRIO_W-1:0]           prio_o
);
  // descending scan with >= leaves the lowest index on a tie
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    prio_o  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand_i[i] && (!valid_o || prio_i[i] >= prio_o)) begin
        valid_o = 1'b1;
        id_o    = SRC_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/vpic_isr_stack.sv
module vpic_isr_stack #(
  parameter int DEPTH = 8,
  parameter int EW    = 8,
  localparam int DEP_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [EW-1:0]    data_i,
  output logic [EW-1:0]    top_o,
  output logic [DEP_W-1:0] depth_o
);
  logic [EW-1:0]    mem_q [DEPTH];
  logic [DEP_W-1:0] depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && depth_q < DEP_W'(DEPTH)) begin
      mem_q[IDX_W'(depth_q)] <= data_i;
      depth_q <= depth_q + 1'b1;
    end else if (pop_i && depth_q != '0) begin
      depth_q <= depth_q - 1'b1;
    end
  end

  assign top_o   = (depth_q != '0) ? mem_q[IDX_W'(depth_q - 1'b1)] : '0;
  assign depth_o = depth_q;
endmodule

// File: rtl/vpic_ctrl.sv
module vpic_ctrl
  import vpic_pkg::*;
#(
  parameter int NSYS = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSYS-1:0] sys_src_i,
  input  logic            bus_en_i,
  input  logic            bus_we_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  output logic [DW-1:0]   bus_rdata_o,
  output logic            irq_o,
  output logic            fiq_o
);
  localparam int DEPTH = 1 << PRIO_W;
  localparam int EW    = SRC_W + PRIO_W;
  localparam int DEP_W = $clog2(DEPTH + 1);

  logic [NSRC-1:0][PRIO_W-1:0] prio_q;
  logic [NSRC-1:0][DW-1:0]     vec_q;
  logic [NSRC-1:0]             level_q, lowpol_q, en_q;
  logic [DW-1:0]               rdata_q, rdata_d;

  logic [NSRC-1:0] raw, pend, cand, clr;
  logic            win_valid, eligible, busy;
  logic [SRC_W-1:0]  win_id, top_src;
  logic [PRIO_W-1:0] win_prio, top_prio;
  logic [EW-1:0]     top_ent;
  logic [DEP_W-1:0]  stk_depth;
  logic rd, wr, vec_rd, fvec_rd, eoi_wr, push, pop;
  logic [SRC_W-1:0]       idx;
  logic [AW-SRC_W-1:0]    region;

  assign raw  = {src_i[NSRC-1:2], |sys_src_i, src_i[0]};
  assign cand = pend & en_q & ~NSRC'(1);

  assign rd      = bus_en_i & ~bus_we_i;
  assign wr      = bus_en_i & bus_we_i;
  assign idx     = bus_addr_i[SRC_W-1:0];
  assign region  = bus_addr_i[AW-1:SRC_W];
  assign vec_rd  = rd && bus_addr_i == A_VEC;
  assign fvec_rd = rd && bus_addr_i == A_FVEC;
  assign eoi_wr  = wr && bus_addr_i == A_EOI;

  assign busy     = stk_depth != '0;
  assign top_src  = top_ent[EW-1:PRIO_W];
  assign top_prio = top_ent[PRIO_W-1:0];
  assign eligible = win_valid && (!busy || win_prio > top_prio);
  assign push     = vec_rd & eligible;
  assign pop      = eoi_wr;
  assign irq_o    = eligible;
  assign fiq_o    = pend[0] & en_q[0];

  always_comb begin
    clr = '0;
    if (push)    clr[win_id] = 1'b1;
    if (fvec_rd) clr[0] = 1'b1;
  end

  vpic_src_cond #(.NSRC(NSRC), .EXT_MASK(EXT_MASK)) u_cond (
    .clk_i, .rst_ni, .raw_i(raw), .level_i(level_q), .lowpol_i(lowpol_q),
    .clr_i(clr), .pend_o(pend)
  );

  vpic_prio_sel #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_sel (
    .cand_i(cand), .prio_i(prio_q), .valid_o(win_valid), .id_o(win_id), .prio_o(win_prio)
  );

  vpic_isr_stack #(.DEPTH(DEPTH), .EW(EW)) u_stk (
    .clk_i, .rst_ni, .push_i(push), .pop_i(pop), .data_i({win_id, win_prio}),
    .top_o(top_ent), .depth_o(stk_depth)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q   <= '0;
      vec_q    <= '0;
      level_q  <= '0;
      lowpol_q <= '0;
      en_q     <= '0;
    end else if (wr) begin
      if (region == '0) begin
        prio_q[idx]   <= bus_wdata_i[PRIO_W-1:0];
        level_q[idx]  <= bus_wdata_i[LVL_BIT];
        lowpol_q[idx] <= bus_wdata_i[POL_BIT];
      end else if (region == 1) begin
        vec_q[idx] <= bus_wdata_i;
      end else if (bus_addr_i == A_EN_SET) begin
        en_q <= en_q | bus_wdata_i[NSRC-1:0];
      end else if (bus_addr_i == A_EN_CLR) begin
        en_q <= en_q & ~bus_wdata_i[NSRC-1:0];
      end
    end
  end

  always_comb begin
    rdata_d = '0;
    if (region == '0) begin
      rdata_d[PRIO_W-1:0] = prio_q[idx];
      rdata_d[LVL_BIT]    = level_q[idx];
      rdata_d[POL_BIT]    = lowpol_q[idx];
    end else if (region == 1) begin
      rdata_d = vec_q[idx];
    end else begin
      case (bus_addr_i)
        A_EN_SET: rdata_d = DW'(en_q);
        A_PEND:   rdata_d = DW'(pend);
        A_VEC:    rdata_d = eligible ? vec_q[win_id] : '0;
        A_CUR:    rdata_d = busy ? {1'b1, (DW-1-SRC_W)'(0), top_src} : '0;
        A_FVEC:   rdata_d = vec_q[0];
        default:  rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rdata_d;
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/vpic_ctrl_chk.sv
module vpic_ctrl_chk
  import vpic_pkg::*;
#(
  localparam int DEPTH = 1 << PRIO_W,
  localparam int DEP_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic [NSRC-1:0]   cand,
  input logic [DEP_W-1:0]  stk_depth,
  input logic              push,
  input logic              pop,
  input logic [PRIO_W-1:0] win_prio,
  input logic [PRIO_W-1:0] top_prio
);
  assert_irq_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (cand != '0));

  assert_push_depth_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> stk_depth == $past(stk_depth) + 1'b1);

  assert_push_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |=> top_prio == $past(win_prio));

  assert_pop_depth_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && stk_depth != '0) |=> stk_depth == $past(stk_depth) - 1'b1);

  assert_stack_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_depth <= DEP_W'(DEPTH));
endmodule

bind vpic_ctrl vpic_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .irq_o(irq_o), .cand(cand),
  .stk_depth(stk_depth), .push(push), .pop(pop),
  .win_prio(win_prio), .top_prio(top_prio)
);

// File: tb/vpic_ctrl_bench.sv
`timescale 1ns/1ps
module vpic_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic [3:0]  sys_src_i = '0;
  logic        bus_en_i = 1'b0, bus_we_i = 1'b0;
  logic [7:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o, fiq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  vpic_ctrl u_vpic_ctrl (.*);

  always #2 clk_i = ~clk_i;

  // monitor: compare each read result against the queued expectation
  always @(posedge clk_i) rd_seen <= bus_en_i & ~bus_we_i;
  always @(negedge clk_i) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (bus_rdata_o !== e) begin
        n_fail++;
        $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata_o, e);
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_en_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk_i);
    bus_en_i = 0; bus_we_i = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] e, string t);
    bus_en_i = 1; bus_we_i = 0; bus_addr_i = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk_i);
    bus_en_i = 0;
  endtask

  task automatic chk(logic act, logic e, string t);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", t, act, e);
    end
  endtask

  task automatic pulse(logic [31:0] m);
    src_i = src_i | m; tick();
    src_i = src_i & ~m; tick();
  endtask

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick();
    chk(irq_o, 0, "R1 irq after reset");
    chk(fiq_o, 0, "R1 fiq after reset");
    rd(8'h40, 32'h0, "R1 enable reset");
    rd(8'h07, 32'h0, "R1 cfg reset");
    rd(8'h27, 32'h0, "R1 vector reset");
    for (int i = 0; i < 32; i++) wr(8'h20 + 8'(i), 32'h1000 + i);

    // R2 / R5: masked edge line, then enabled
    src_i[5] = 1; tick(2);
    chk(irq_o, 0, "R2 disabled line silent");
    rd(8'h43, 32'h20, "R2 pending visible while disabled");
    wr(8'h40, 32'h20);
    rd(8'h40, 32'h20, "R2 enable readback");
    chk(irq_o, 1, "R2 irq after enable");
    src_i[5] = 0; tick(2);
    chk(irq_o, 1, "R5 edge held after input drop");
    rd(8'h44, 32'h1005, "R5 vector on ack");
    chk(irq_o, 0, "R5 irq cleared by ack");
    rd(8'h43, 32'h0, "R5 capture cleared");
    rd(8'h45, 32'h8000_0005, "R10 current source");
    wr(8'h46, 0);
    rd(8'h45, 32'h0, "R10 empty after eoi");

    // R6 level line, prio 2
    wr(8'h07, 32'h22);
    wr(8'h40, 32'h80);
    src_i[7] = 1; tick();
    chk(irq_o, 1, "R6 level raises irq");
    rd(8'h44, 32'h1007, "R6 vector");
    chk(irq_o, 0, "R9 equal prio blocked while in service");
    rd(8'h43, 32'h80, "R6 still pending while held");
    wr(8'h46, 0);
    chk(irq_o, 1, "R6 pending again after eoi");
    src_i[7] = 0; tick();
    chk(irq_o, 0, "R6 drops with input");
    rd(8'h07, 32'h22, "R8 cfg readback");

    // R8 / R9 priority and nesting
    wr(8'h0A, 3); wr(8'h0C, 3); wr(8'h0B, 1); wr(8'h14, 5);
    wr(8'h40, 32'h0010_1C00);
    pulse(32'h0000_1C00);
    chk(irq_o, 1, "R8 irq with three pending");
    rd(8'h44, 32'h100A, "R8 tie goes to lower line");
    chk(irq_o, 0, "R9 equal and lower blocked");
    pulse(32'h0010_0000);
    chk(irq_o, 1, "R9 higher prio nests");
    rd(8'h44, 32'h1014, "R9 nested vector");
    rd(8'h45, 32'h8000_0014, "R10 nested top");
    wr(8'h46, 0);
    rd(8'h45, 32'h8000_000A, "R9 pop restores previous");
    chk(irq_o, 0, "R9 still blocked by line 10");
    wr(8'h46, 0);
    chk(irq_o, 1, "R9 reopened after pop");
    rd(8'h44, 32'h100C, "R8 prio3 before prio1");
    wr(8'h46, 0);
    rd(8'h44, 32'h100B, "R8 last of group");
    wr(8'h46, 0);
    chk(irq_o, 0, "R9 all served");

    // R11 spurious read
    rd(8'h44, 32'h0, "R11 vector with no request");
    rd(8'h45, 32'h0, "R11 no push");

    // R3 fast line
    wr(8'h40, 32'h1);
    pulse(32'h1);
    chk(fiq_o, 1, "R3 fiq raised");
    chk(irq_o, 0, "R3 line 0 not on irq");
    rd(8'h47, 32'h1000, "R3 fast vector");
    chk(fiq_o, 0, "R3 fiq cleared by fast ack");
    rd(8'h45, 32'h0, "R3 fast ack pushes nothing");

    // R7 polarity on external line 31
    src_i[31] = 1; tick();
    wr(8'h1F, 32'h60);
    wr(8'h40, 32'h8000_0000);
    chk(irq_o, 0, "R7 low-level line inactive when high");
    src_i[31] = 0; tick();
    chk(irq_o, 1, "R7 low-level line active when low");
    rd(8'h44, 32'h101F, "R7 vector");
    wr(8'h46, 0);
    src_i[31] = 1; tick();
    chk(irq_o, 0, "R7 released");
    // internal line ignores polarity bit
    wr(8'h08, 32'h60);
    wr(8'h40, 32'h100);
    tick();
    chk(irq_o, 0, "R7 internal line ignores inversion");
    src_i[8] = 1; tick();
    chk(irq_o, 1, "R7 internal line active high");
    rd(8'h44, 32'h1008, "R7 internal vector");
    src_i[8] = 0;
    wr(8'h46, 0);
    chk(irq_o, 0, "R7 internal released");

    // R4 system line
    wr(8'h01, 32'h21);
    wr(8'h40, 32'h2);
    src_i[1] = 1; tick();
    chk(irq_o, 0, "R4 src pin 1 ignored");
    src_i[1] = 0; sys_src_i = 4'b0100; tick();
    chk(irq_o, 1, "R4 system line raises");
    rd(8'h44, 32'h1001, "R4 vector");
    wr(8'h46, 0);
    sys_src_i = 0; tick();
    chk(irq_o, 0, "R4 system line released");

    wr(8'h41, 32'hFFFF_FFFF);
    rd(8'h40, 32'h0, "R2 enable clear");
    tick(2);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule